// File: doc/BRIEF.md
# Watermarked Sequential Controller

This block is a Moore-style controller. It has seven working states and a hidden chain of nine watermark states. In normal operation it steps through a functional transition table. The table is a parameter, indexed by the current working state and a 2-bit input code. Some table entries are marked as free, meaning the plain machine never uses that input code from that state. Applying such a free code moves the controller into the first watermark state. Raising the dedicated `wm_en` input does the same from any working state, whatever input code is present. The `wm_en` path covers the working state whose four input codes are all taken. When `wm_en` is low, the working behaviour is exactly the plain machine's table.

Once inside the chain, the controller advances one watermark state per clock and ignores every input. It walks the whole chain and then drops back to the initial working state. The output bus is the state register itself, with the watermark flag as its top bit. An owner can therefore show a fixed nine-step output signature without changing anything the machine does in normal use.

State encoding follows a fill-free-codes-first rule:
- The 3-bit code space holds the working states S0..S6 at codes 0..6.
- The spare code 7 becomes W1.
- A fourth state bit, the flag, was then added. W2..W9 occupy flag=1 with codes 0..7.

The named transitions are as follows:
- Sx→table: a working state with a used input code and `wm_en` low goes to the table entry.
- Sx→W1 (free code): a working state with a free input code goes to W1.
- Sx→W1 (enable bit): a working state with `wm_en` high goes to W1.
- Wk→Wk+1: each watermark state from W1 to W8 steps to the next one.
- W9→S0: the last watermark state returns to the initial working state.
- Reset goes to S0.

Any encoding that is not a listed state recovers to S0.

Top module: `wm_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts the controller in S0 at the next clock, from any state including mid-chain. After that clock `dout` = 4'h0.
- R2: From working state Sx (dout = {0, x}, x in 0..6) with `wm_en`=0 and a used input code d, the next `dout` is {0, T[x][d]}. T[x][d] is the table entry, default T[x][d] = (x+d+1) mod 7.
- R3: From a working state with `wm_en`=0 and an input code whose table entry is the free marker 7, the next state is W1 (dout = 4'h7). By default code 3 is free in every state except S3.
- R4: From any working state with `wm_en`=1, the next state is W1 (dout = 4'h7), whatever `din` is.
- R5: The watermark states step W1→W2→…→W9, one per clock, whatever `din` and `wm_en` are. W1 is 4'h7 and Wk (k=2..9) is {1, k-2}, so the chain outputs 4'h7 and then 4'h8 through 4'hF.
- R6: From W9 (dout = 4'hF) the next state is S0 (dout = 4'h0), whatever the inputs are.
- R7: `dout[3]` (the flag) is 0 in every working state, and a working state's `dout[2:0]` never reads 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset to S0 |
| din | input | 2 | Functional input code |
| wm_en | input | 1 | Extra bit: high forces entry to W1 from any working state |
| dout | output | 4 | Registered state: {flag, code[2:0]} |

## Verification
Every working state is reached from S0 and then hit with all four input codes, each with `wm_en` low and high. This separates table transitions from free-code entries and from enable-bit entries. It also covers S3, which has no free code. Every chain entry is followed through W9 with random inputs driven each cycle. This shows that the nine-step signature and the return to S0 do not depend on the inputs. A reset issued mid-chain and a long random walk compared against an arithmetic model of the full machine cover the remaining orderings.

// File: rtl/wm_pkg.sv
`timescale 1ns/1ps
package wm_pkg;
    localparam int IN_W      = 2;
    localparam int N_IN      = 1 << IN_W;
    localparam int N_WORK    = 7;
    localparam int CODE_W    = 3;
    localparam int ST_W      = CODE_W + 1;
    localparam int TBL_W     = N_WORK * N_IN * CODE_W;
    localparam int FULL_ST   = 3;
    localparam logic [CODE_W-1:0] FREE_CODE = CODE_W'(N_WORK);

    typedef enum logic [ST_W-1:0] {
        S0 = 4'h0, S1 = 4'h1, S2 = 4'h2, S3 = 4'h3,
        S4 = 4'h4, S5 = 4'h5, S6 = 4'h6,
        W1 = 4'h7, W2 = 4'h8, W3 = 4'h9, W4 = 4'hA,
        W5 = 4'hB, W6 = 4'hC, W7 = 4'hD, W8 = 4'hE, W9 = 4'hF
    } st_e;

    // Default working table: code N_IN-1 is free except in FULL_ST.
    function automatic logic [TBL_W-1:0] default_table();
        logic [TBL_W-1:0] t;
        t = '0;
        for (int s = 0; s < N_WORK; s++) begin
            for (int i = 0; i < N_IN; i++) begin
                if (i == N_IN - 1 && s != FULL_ST)
                    t[(s*N_IN+i)*CODE_W +: CODE_W] = FREE_CODE;
                else
                    t[(s*N_IN+i)*CODE_W +: CODE_W] = CODE_W'((s + i + 1) % N_WORK);
            end
        end
        return t;
    endfunction
endpackage

// File: rtl/wm_work_next.sv
`timescale 1ns/1ps
module wm_work_next
    import wm_pkg::*;
#(
    parameter logic [TBL_W-1:0] TBL = default_table()
) (
    input  logic [CODE_W-1:0] code,
    input  logic [IN_W-1:0]   din,
    output logic [CODE_W-1:0] nxt_code,
    output logic              free
);
    logic [CODE_W+IN_W-1:0] idx;

    always_comb begin
        idx = {code, din};
        if (int'(code) < N_WORK)
            nxt_code = TBL[CODE_W*int'(idx) +: CODE_W];
        else
            nxt_code = FREE_CODE;
        free = (nxt_code == FREE_CODE);
    end
endmodule

// File: rtl/wm_chain_next.sv
`timescale 1ns/1ps
module wm_chain_next
    import wm_pkg::*;
(
    input  st_e cur,
    output st_e nxt
);
    always_comb begin
        unique case (cur)
            W1:      nxt = W2;
            W2:      nxt = W3;
            W3:      nxt = W4;
            W4:      nxt = W5;
            W5:      nxt = W6;
            W6:      nxt = W7;
            W7:      nxt = W8;
            W8:      nxt = W9;
            W9:      nxt = S0;
            default: nxt = S0;
        endcase
    end
endmodule

// File: rtl/wm_ctrl.sv
`timescale 1ns/1ps
module wm_ctrl
    import wm_pkg::*;
#(
    parameter logic [TBL_W-1:0] NEXT_TBL = default_table()
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IN_W-1:0] din,
    input  logic            wm_en,
    output logic [ST_W-1:0] dout
);
    st_e               state;
    st_e               state_n;
    st_e               chain_n;
    logic [CODE_W-1:0] work_code;
    logic              work_free;

    wm_work_next #(.TBL(NEXT_TBL)) u_work (
        .code     (state[CODE_W-1:0]),
        .din      (din),
        .nxt_code (work_code),
        .free     (work_free)
    );

    wm_chain_next u_chain (
        .cur (state),
        .nxt (chain_n)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state <= S0;
        else
            state <= state_n;
    end

    // next-state selection
    always_comb begin
        unique case (state)
            S0, S1, S2, S3, S4, S5, S6: begin
                if (wm_en || work_free)
                    state_n = W1;
                else
                    state_n = st_e'({1'b0, work_code});
            end
            W1, W2, W3, W4, W5, W6, W7, W8, W9:
                state_n = chain_n;
            default:
                state_n = S0;
        endcase
    end

    // outputs: flag bit over the lower code bits
    always_comb begin
        dout = state;
    end
endmodule

// File: rtl/wm_ctrl_chk.sv
`timescale 1ns/1ps
module wm_ctrl_chk
    import wm_pkg::*;
#(
    parameter logic [TBL_W-1:0] TBL = default_table()
) (
    input logic            clk,
    input logic            rst,
    input logic [IN_W-1:0] din,
    input logic            wm_en,
    input logic [ST_W-1:0] dout
);
    logic working;
    logic [CODE_W-1:0] entry;

    always_comb begin
        working = !dout[ST_W-1] && (int'(dout[CODE_W-1:0]) < N_WORK);
        entry   = working ? TBL[CODE_W*int'({dout[CODE_W-1:0], din}) +: CODE_W] : FREE_CODE;
    end

    // R2
    table_stays_working_chk: assert property (@(posedge clk) disable iff (rst)
        working && !wm_en && entry != FREE_CODE |=> !dout[ST_W-1]);

    // R3
    free_code_entry_chk: assert property (@(posedge clk) disable iff (rst)
        working && !wm_en && entry == FREE_CODE |=> dout == 4'h7);

    // R4
    enable_entry_chk: assert property (@(posedge clk) disable iff (rst)
        working && wm_en |=> dout == 4'h7);

    // R5
    first_step_chk: assert property (@(posedge clk) disable iff (rst)
        dout == 4'h7 |=> dout == 4'h8);

    // R5
    chain_step_chk: assert property (@(posedge clk) disable iff (rst)
        dout[ST_W-1] && dout != 4'hF |=> dout == $past(dout) + 4'h1);

    // R6
    chain_exit_chk: assert property (@(posedge clk) disable iff (rst)
        dout == 4'hF |=> dout == 4'h0);
endmodule

bind wm_ctrl wm_ctrl_chk #(.TBL(NEXT_TBL)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .din   (din),
    .wm_en (wm_en),
    .dout  (dout)
);

// File: tb/sim_wm_ctrl.sv
`timescale 1ns/1ps
module sim_wm_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] din = 2'd0;
    logic       wm_en = 1'b0;
    logic [3:0] dout;
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    wm_ctrl u0 (.clk(clk), .rst(rst), .din(din), .wm_en(wm_en), .dout(dout));

    // table from the requirements: code 3 free except in S3
    function automatic int tbl(input int s, input int i);
        if (i == 3 && s != 3) return 7;
        return (s + i + 1) % 7;
    endfunction

    function automatic int model(input int st, input int d, input bit e);
        if (st < 7) return (e || tbl(st, d) == 7) ? 7 : tbl(st, d);
        if (st == 15) return 0;
        return st + 1;
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic step(input logic [1:0] d, input logic e);
        din = d; wm_en = e;
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(2'd0, 1'b0);
        rst = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int st;
        #1;
        step(2'd2, 1'b1);
        step(2'd1, 1'b0);
        chk("R1 reset state", dout, 0);
        rst = 1'b0;

        for (int s = 0; s < 7; s++) begin
            for (int i = 0; i < 4; i++) begin
                for (int e = 0; e < 2; e++) begin
                    do_reset();
                    chk("R1 reset", dout, 0);
                    for (int k = 0; k < s; k++) begin
                        step(2'd0, 1'b0);
                        chk("R2 walk", dout, k + 1);
                        chk("R7 flag low", dout[3], 0);
                    end
                    step(2'(i), 1'(e));
                    if (e == 1)
                        chk("R4 enable entry", dout, 7);
                    else if (tbl(s, i) == 7)
                        chk("R3 free code entry", dout, 7);
                    else begin
                        chk("R2 table", dout, tbl(s, i));
                        chk("R7 flag low", dout[3], 0);
                    end
                    if (dout == 4'h7) begin
                        for (int k = 0; k < 8; k++) begin
                            step(2'($urandom), 1'($urandom));
                            chk("R5 chain step", dout, 8 + k);
                        end
                        step(2'($urandom), 1'($urandom));
                        chk("R6 chain exit", dout, 0);
                    end
                end
            end
        end

        // reset in mid-chain
        do_reset();
        step(2'd3, 1'b0);
        step(2'd1, 1'b1);
        step(2'd2, 1'b1);
        chk("R5 mid chain", dout, 9);
        rst = 1'b1;
        step(2'd3, 1'b1);
        chk("R1 reset mid chain", dout, 0);
        rst = 1'b0;

        // random walk against the full model
        do_reset();
        st = 0;
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] d;
            logic e;
            d = 2'($urandom);
            e = (($urandom % 8) == 0);
            st = model(st, int'(d), e);
            step(d, e);
            chk("R2/R5 random walk", dout, st);
            if (st < 7) chk("R7 flag in walk", dout[3], 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule